// File: doc/BRIEF.md
# Double-Precision Multiply Special-Operand Resolver

This combinational unit sits in front of a double-precision multiplier. It inspects both 64-bit IEEE-754 operands and settles every case the multiplier array does not need to compute: NaN inputs, infinities, zeros and the invalid product of infinity and zero. When such a case applies, it supplies the finished result on a bypass path. When both operands are finite and nonzero, it hands control to the normal datapath.

NaN handling uses a fixed operand priority. A set most significant fraction bit marks a signaling NaN. Quieting clears that bit. An invalid operation either raises a trap request, which suppresses the result write, or sets the invalid flag, depending on the trap-enable input.

Top module: `fmul_special_resolve`

## Requirements
- R1: With the trap disabled, infinity times zero in either order sets invalid_o, asserts bypass_valid_o and returns the default quiet NaN 64'h7FF4_0000_0000_0000.
- R2: Every invalid case with trap_en_i high asserts trap_o. In that case bypass_valid_o, invalid_o and proceed_o stay low and bypass_result_o is zero.
- R3: If operand 1 is a signaling NaN (exponent all ones, fraction bit 51 set), the invalid condition is raised and the result is operand 1 quieted, whatever operand 2 holds.
- R4: If operand 1 is a quiet NaN (exponent all ones, bit 51 clear, fraction nonzero) and operand 2 is a signaling NaN, the invalid condition is raised and the result is operand 2 quieted. If both are quiet, the result is operand 1 and no flag is raised.
- R5: If operand 2 is a NaN and operand 1 is not a NaN (finite or infinite), the result is operand 2. If operand 2 is signaling, it is quieted and the invalid condition is raised.
- R6: Quieting clears fraction bit 51 and keeps the sign and the other bits. If the remaining fraction would then be zero, bit 0 is set so the value stays a NaN.
- R7: Infinity times infinity, or infinity times a finite nonzero value, returns an infinity whose sign is the XOR of the operand signs, with no flags.
- R8: Zero times a finite value returns a zero whose sign is the XOR of the operand signs, with no flags.
- R9: proceed_o is high exactly when both operands are finite and nonzero, subnormals included. In that case bypass_result_o is zero.
- R10: For every input, exactly one of bypass_valid_o, trap_o and proceed_o is high.
- R11: trap_en_i has no effect on any output when no invalid condition is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 64 | First operand, IEEE-754 double |
| op_b_i | input | 64 | Second operand, IEEE-754 double |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| bypass_valid_o | output | 1 | Special result is on bypass_result_o |
| bypass_result_o | output | 64 | Special-case result, zero when not valid |
| invalid_o | output | 1 | Request to set the invalid flag |
| trap_o | output | 1 | Invalid trap request, result write suppressed |
| proceed_o | output | 1 | Both operands finite and nonzero; use the datapath |

## Verification
NaN selection and invalid-product detection can apply to the same input pair. For example, operand 1 can be a signaling NaN while operand 2 is zero or infinity, or operand 1 can be an infinity while operand 2 is a signaling NaN. In every such pair the NaN rules must win, and the invalid condition must come only from the signaling operand. The bench provokes these overlaps with directed pairs and with random pairs biased toward special classes and random trap enables. Every cycle it judges the full output set against a behavioural model that applies the priority rules in order.

// File: rtl/fmul_sr_pkg.sv
package fmul_sr_pkg;
  typedef struct packed {
    logic nan;
    logic snan;
    logic inf;
    logic zero;
  } fsr_class_t;
endpackage

// File: rtl/fmul_sr_classify.sv
module fmul_sr_classify
  import fmul_sr_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output fsr_class_t   cls_o,
  output logic [W-1:0] quiet_o
);
  logic exp_max, exp_min, frac_nz;

  assign exp_max = &op_i[W-2:FRAC_W];
  assign exp_min = ~|op_i[W-2:FRAC_W];
  assign frac_nz = |op_i[FRAC_W-1:0];

  always_comb begin
    cls_o.nan  = exp_max & frac_nz;
    cls_o.snan = exp_max & op_i[FRAC_W-1];
    cls_o.inf  = exp_max & ~frac_nz;
    cls_o.zero = exp_min & ~frac_nz;
  end

  // clear the signaling bit; keep a nonzero payload
  always_comb begin
    quiet_o = op_i;
    quiet_o[FRAC_W-1] = 1'b0;
    if (~|op_i[FRAC_W-2:0]) quiet_o[0] = 1'b1;
  end
endmodule

// File: rtl/fmul_sr_nan_pick.sv
module fmul_sr_nan_pick
  import fmul_sr_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  fsr_class_t   cls_a_i,
  input  fsr_class_t   cls_b_i,
  input  logic [W-1:0] quiet_a_i,
  input  logic [W-1:0] quiet_b_i,
  output logic         hit_o,
  output logic         sig_o,
  output logic [W-1:0] res_o
);
  logic take_b;

  // operand 1 wins unless it is not a NaN or only operand 2 signals
  assign take_b = ~cls_a_i.nan | (~cls_a_i.snan & cls_b_i.snan);
  assign hit_o  = cls_a_i.nan | cls_b_i.nan;
  assign sig_o  = take_b ? cls_b_i.snan : cls_a_i.snan;
  assign res_o  = take_b ? quiet_b_i : quiet_a_i;
endmodule

// File: rtl/fmul_special_resolve.sv
module fmul_special_resolve
  import fmul_sr_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         trap_en_i,
  output logic         bypass_valid_o,
  output logic [W-1:0] bypass_result_o,
  output logic         invalid_o,
  output logic         trap_o,
  output logic         proceed_o
);
  localparam logic [W-1:0] DFLT_QNAN =
    {1'b0, {EXP_W{1'b1}}, 2'b01, {(FRAC_W-2){1'b0}}};

  logic [W-1:0] ops   [2];
  logic [W-1:0] quiet [2];
  fsr_class_t   cls   [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fmul_sr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .op_i   (ops[g]),
      .cls_o  (cls[g]),
      .quiet_o(quiet[g])
    );
  end

  logic         nan_hit, nan_sig;
  logic [W-1:0] nan_res;

  fmul_sr_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_pick (
    .cls_a_i  (cls[0]),
    .cls_b_i  (cls[1]),
    .quiet_a_i(quiet[0]),
    .quiet_b_i(quiet[1]),
    .hit_o    (nan_hit),
    .sig_o    (nan_sig),
    .res_o    (nan_res)
  );

  logic sign_x, inf_zero, any_inf, any_zero, special, raise;

  assign sign_x   = op_a_i[W-1] ^ op_b_i[W-1];
  assign inf_zero = (cls[0].inf & cls[1].zero) | (cls[0].zero & cls[1].inf);
  assign any_inf  = cls[0].inf | cls[1].inf;
  assign any_zero = cls[0].zero | cls[1].zero;
  assign special  = nan_hit | any_inf | any_zero;
  assign raise    = nan_hit ? nan_sig : inf_zero;

  assign trap_o         = raise & trap_en_i;
  assign invalid_o      = raise & ~trap_en_i;
  assign proceed_o      = ~special;
  assign bypass_valid_o = special & ~trap_o;

  always_comb begin
    bypass_result_o = '0;
    if (bypass_valid_o) begin
      if (nan_hit)       bypass_result_o = nan_res;
      else if (inf_zero) bypass_result_o = DFLT_QNAN;
      else if (any_inf)  bypass_result_o = {sign_x, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else               bypass_result_o = {sign_x, {(W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fmul_sr_checker.sv
module fmul_sr_checker #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic         trap_en_i,
  input logic         bypass_valid_o,
  input logic [W-1:0] bypass_result_o,
  input logic         invalid_o,
  input logic         trap_o,
  input logic         proceed_o
);
  logic res_nan, res_inf, a_fin_nz, b_fin_nz;

  assign res_nan  = (&bypass_result_o[W-2:FRAC_W]) & (|bypass_result_o[FRAC_W-1:0]);
  assign res_inf  = (&bypass_result_o[W-2:FRAC_W]) & ~(|bypass_result_o[FRAC_W-1:0]);
  assign a_fin_nz = ~(&op_a_i[W-2:FRAC_W]) & (|op_a_i[W-2:0]);
  assign b_fin_nz = ~(&op_b_i[W-2:FRAC_W]) & (|op_b_i[W-2:0]);

  always_comb begin
    a_r10_one_outcome: assert ($countones({bypass_valid_o, trap_o, proceed_o}) == 1);
    a_r2_trap_no_flag: assert (!(trap_o && (invalid_o || bypass_result_o != '0)));
    a_r2_trap_needs_en: assert (!trap_o || trap_en_i);
    a_r6_nan_out_quiet: assert (!(bypass_valid_o && res_nan) || !bypass_result_o[FRAC_W-1]);
    a_r1_invalid_gives_nan: assert (!invalid_o || (bypass_valid_o && res_nan));
    a_r9_proceed_operands: assert (!proceed_o || (a_fin_nz && b_fin_nz));
    a_r7_inf_sign: assert (!(bypass_valid_o && res_inf) ||
                           bypass_result_o[W-1] == (op_a_i[W-1] ^ op_b_i[W-1]));
  end
endmodule

bind fmul_special_resolve fmul_sr_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .op_a_i         (op_a_i),
  .op_b_i         (op_b_i),
  .trap_en_i      (trap_en_i),
  .bypass_valid_o (bypass_valid_o),
  .bypass_result_o(bypass_result_o),
  .invalid_o      (invalid_o),
  .trap_o         (trap_o),
  .proceed_o      (proceed_o)
);

// File: tb/test_fmul_special_resolve.sv
module test_fmul_special_resolve;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic [63:0] op_a, op_b, res;
  logic        te, bv, inv, trp, prc;
  int          checks = 0, errors = 0;

  fmul_special_resolve i_fmul_special_resolve (
    .op_a_i(op_a), .op_b_i(op_b), .trap_en_i(te),
    .bypass_valid_o(bv), .bypass_result_o(res),
    .invalid_o(inv), .trap_o(trp), .proceed_o(prc)
  );

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] QDEF = 64'h7FF4_0000_0000_0000;

  function automatic bit is_nan(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction
  function automatic bit is_inf(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] == 0;
  endfunction
  function automatic bit is_zero(input logic [63:0] x);
    return x[62:0] == 0;
  endfunction
  function automatic bit is_sig(input logic [63:0] x);
    return is_nan(x) && x[51];
  endfunction
  function automatic logic [63:0] quieten(input logic [63:0] x);
    logic [63:0] y = x & ~(64'd1 << 51);
    if (y[50:0] == 0) y = y + 64'd1;
    return y;
  endfunction

  // expected {bv, trap, inv, proceed, result} and the rule that applied
  function automatic logic [67:0] model(input logic [63:0] a, b, input logic t,
                                        output string tag);
    logic [63:0] r;
    bit bad;
    logic s = a[63] ^ b[63];
    bad = 0; r = 0;
    if (is_nan(a) && (is_sig(a) || !is_sig(b))) begin
      tag = is_sig(a) ? "R3" : (is_nan(b) ? "R4" : "R3");
      bad = is_sig(a); r = quieten(a);
    end else if (is_nan(b)) begin
      tag = is_nan(a) ? "R4" : "R5";
      bad = is_sig(b); r = quieten(b);
    end else if ((is_inf(a) && is_zero(b)) || (is_zero(a) && is_inf(b))) begin
      tag = "R1"; bad = 1; r = QDEF;
    end else if (is_inf(a) || is_inf(b)) begin
      tag = "R7"; r = {s, PINF[62:0]};
    end else if (is_zero(a) || is_zero(b)) begin
      tag = "R8"; r = {s, 63'd0};
    end else begin
      tag = "R9";
      return {4'b0001, 64'd0};
    end
    if (bad && t) begin
      tag = {tag, "/R2"};
      return {4'b0100, 64'd0};
    end
    return {1'b1, 1'b0, bad, 1'b0, r};
  endfunction

  task automatic apply(input logic [63:0] a, b, input logic t);
    string tag;
    logic [67:0] exp_v, act_v;
    @(posedge clk);
    op_a = a; op_b = b; te = t;
    @(negedge clk);
    exp_v = model(a, b, t, tag);
    act_v = {bv, trp, inv, prc, res};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s a=%h b=%h te=%b actual=%h expected=%h", tag, a, b, t, act_v, exp_v);
    end
  endtask

  task automatic expect_res(input string tag, input logic [63:0] want);
    checks++;
    if (res !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, res, want);
    end
  endtask

  function automatic logic [63:0] pick(input int k);
    logic [63:0] f = {$urandom, $urandom};
    logic        sg = f[63];
    case (k)
      0: return {sg, 63'd0};
      1: return {sg, 11'd0, f[51:1], 1'b1};
      2: return {sg, 11'(1 + (f[62:52] % 11'h7FE)), f[51:0]};
      3: return {sg, PINF[62:0]};
      4: return {sg, 11'h7FF, 1'b0, f[50:1], 1'b1};
      default: return {sg, 11'h7FF, 1'b1, (f[0] ? f[50:0] : 51'd0)};
    endcase
  endfunction

  initial begin
    #800us;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    op_a = 0; op_b = 0; te = 0;
    // initial state: zero times zero
    apply(64'd0, 64'd0, 0);                                   // R8
    apply(PINF, 64'h8000_0000_0000_0000, 0);                  // R1
    expect_res("R1", QDEF);
    apply(64'h0, 64'hFFF0_0000_0000_0000, 0);                 // R1 reversed
    apply(PINF, 64'd0, 1);                                    // R2
    apply(64'h7FF8_0000_0000_0000, 64'd0, 0);                 // R3 with R6 payload
    expect_res("R6", 64'h7FF0_0000_0000_0001);
    apply(64'hFFF8_0000_0000_1234, 64'h7FF8_0000_0000_0000, 0); // R3 both signaling
    expect_res("R3", 64'hFFF0_0000_0000_1234);
    apply(64'h7FF8_0000_0000_0005, PINF, 1);                  // R3 trap
    apply(64'h7FF0_0000_0000_0007, 64'hFFF8_0000_0000_0009, 0); // R4
    expect_res("R4", 64'hFFF0_0000_0000_0009);
    apply(64'h7FF0_0000_0000_0007, 64'h7FF4_0000_0000_0000, 0); // R4 both quiet
    apply(PINF, 64'h7FF8_0000_0000_0000, 0);                  // R5 inf with sNaN
    apply(64'h3FF0_0000_0000_0000, 64'hFFF2_0000_0000_0000, 1); // R5 quiet, R11
    apply(64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 0); // R7
    apply(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001, 1); // R7 subnormal, R11
    apply(64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 1); // R8, R11
    apply(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0003, 0); // R9 subnormals
    apply(64'h7FEF_FFFF_FFFF_FFFF, 64'h3FF0_0000_0000_0000, 1); // R9
    for (int i = 0; i < 4000; i++)
      apply(pick($urandom_range(0, 5)), pick($urandom_range(0, 5)), 1'($urandom)); // R10
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule